// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Lock

This block watches for a stalled system. A 32-bit down-counter runs from a programmable reload value. When it reaches zero it reloads and flags a pending interrupt. Software is expected to service that interrupt by writing the interrupt-clear register, which also restarts the count. If the counter runs out a second time while the first interrupt is still pending, the block drives a reset request, provided reset generation is enabled. Without service, reset therefore comes about two reload periods after the count starts.

Software reaches the block through a simple memory-mapped register port with select, access-phase and write strobes. To guard against stray writes, every register except the lock register refuses writes until a key word has been written to the lock register. Writing any other word to the lock register shuts the gate again. Reads are always allowed.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the lock register reads 1, control reads 0, the reload register and the counter read 0xFFFFFFFF, and both the interrupt and reset outputs are low.
- R2: A write of 0x1ACCE551 to offset 0xC00 makes that register read 0 (open). A write of any other word makes it read 1 (shut).
- R3: While shut, writes to offsets 0x000, 0x008 and 0x00C change nothing.
- R4: A write to offset 0x000 while open sets the reload value and loads the counter with it on the same clock edge. Offset 0x004 reads the counter.
- R5: While control bit 0 is set, the counter drops by one per clock. While it is clear, the counter holds.
- R6: The counter expires on an enabled clock at which it reads zero. Expiry reloads the counter and sets the pending flag, so the first expiry comes L+1 clocks after a load of L.
- R7: Offset 0x014 bit 0 reads the pending flag. The interrupt output is the pending flag ANDed with control bit 0.
- R8: Any write to offset 0x00C while open clears the pending flag and reloads the counter from the reload register.
- R9: An expiry while the pending flag is set and control bit 1 is set raises the reset output, which then stays high until system reset. Unserviced, this happens 2*(L+1) clocks after a load of L.
- R10: An expiry while the pending flag is set and control bit 1 is clear leaves the reset output low.
- R11: Control bits 31:2 read 0. Offset 0x00C and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase; a write takes effect on this cycle's edge |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq | output | 1 | Interrupt: pending flag gated by control bit 0 |
| wdt_rst | output | 1 | Sticky reset request |

## Verification
The directed patterns cover several cases. Shut-gate writes are compared against the same writes made after the key, which separates lock handling from plain register storage. A disabled counter is checked against an enabled one to confirm hold against decrement. Clearing the interrupt enable while an interrupt is pending checks that the flag and the output are kept apart. Random reload values from 0 to 23, each with a random reset-enable bit, time the first and second expiry to the exact clock. These runs catch off-by-one periods and show reset arising only when the enable bit is set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned OFF_LOAD   = 32'h000;
  localparam int unsigned OFF_VALUE  = 32'h004;
  localparam int unsigned OFF_CTRL   = 32'h008;
  localparam int unsigned OFF_CLEAR  = 32'h00C;
  localparam int unsigned OFF_STATUS = 32'h014;
  localparam int unsigned OFF_LOCK   = 32'hC00;
  localparam logic [31:0] KEY_DEFAULT = 32'h1ACCE551;
  localparam int unsigned CTRL_W = 2;
  typedef struct packed {
    logic rst_en;
    logic run_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate
  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [DATA_W-1:0] KEY = KEY_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] count,
  input  logic              pend,
  output logic [DATA_W-1:0] prdata,
  output logic [DATA_W-1:0] load_q,
  output ctrl_t             ctrl_q,
  output logic              load_wr,
  output logic              clr_wr
);
  localparam int unsigned PAD_W = DATA_W - CTRL_W;

  logic              locked_q, locked_d;
  logic [DATA_W-1:0] load_d;
  ctrl_t             ctrl_d;
  logic              wr_acc, open_wr, lock_wr, ctrl_wr;

  always_comb begin
    wr_acc  = psel & penable & pwrite;
    open_wr = wr_acc & ~locked_q;
    lock_wr = wr_acc  & (paddr == ADDR_W'(OFF_LOCK));
    load_wr = open_wr & (paddr == ADDR_W'(OFF_LOAD));
    ctrl_wr = open_wr & (paddr == ADDR_W'(OFF_CTRL));
    clr_wr  = open_wr & (paddr == ADDR_W'(OFF_CLEAR));
    locked_d = lock_wr ? (pwdata != KEY) : locked_q;
    load_d   = load_wr ? pwdata : load_q;
    ctrl_d   = ctrl_wr ? ctrl_t'(pwdata[CTRL_W-1:0]) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      load_q   <= '1;
      ctrl_q   <= '0;
    end else begin
      locked_q <= locked_d;
      load_q   <= load_d;
      ctrl_q   <= ctrl_d;
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr == ADDR_W'(OFF_LOAD))        prdata = load_q;
    else if (paddr == ADDR_W'(OFF_VALUE))  prdata = count;
    else if (paddr == ADDR_W'(OFF_CTRL))   prdata = {{PAD_W{1'b0}}, ctrl_q};
    else if (paddr == ADDR_W'(OFF_STATUS)) prdata = {{(DATA_W-1){1'b0}}, pend};
    else if (paddr == ADDR_W'(OFF_LOCK))   prdata = {{(DATA_W-1){1'b0}}, locked_q};
  end

  AST_SHUT_LOAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(load_q)); // R3
  AST_SHUT_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(ctrl_q)); // R3
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && paddr == ADDR_W'(OFF_LOCK) && pwdata == KEY) |=> !locked_q); // R2
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_wdata,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] count,
  output logic              expire
);
  logic [DATA_W-1:0] count_d;
  logic              at_zero, reload_req;

  always_comb begin
    at_zero    = (count == '0);
    reload_req = load_wr | clr_wr;
    expire     = run_en & at_zero & ~reload_req;
    count_d    = count;
    if (load_wr)      count_d = load_wdata;
    else if (clr_wr)  count_d = load_q;
    else if (expire)  count_d = load_q;
    else if (run_en)  count_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '1;
    else        count <= count_d;
  end

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_wr && !clr_wr) |=> $stable(count)); // R5
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && count != '0 && !load_wr && !clr_wr) |=> count == $past(count) - 1'b1); // R5
  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(load_q)); // R6
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_wr,
  input  logic int_en,
  input  logic rst_en,
  output logic pend,
  output logic irq,
  output logic wdt_rst
);
  logic pend_d, rst_d;

  always_comb begin
    pend_d = pend;
    if (clr_wr)      pend_d = 1'b0;
    else if (expire) pend_d = 1'b1;
    rst_d = wdt_rst | (expire & pend & rst_en);
    irq   = pend & int_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      wdt_rst <= 1'b0;
    end else begin
      pend    <= pend_d;
      wdt_rst <= rst_d;
    end
  end

  AST_PEND_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !pend); // R8
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> wdt_rst); // R9
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> ($past(pend) && $past(rst_en))); // R10
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] KEY   = KEY_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq,
  output logic              wdt_rst
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] count, load_q;
  ctrl_t             ctrl_q;
  logic              load_wr, clr_wr, expire, pend;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .count(count),
    .pend(pend), .prdata(prdata), .load_q(load_q), .ctrl_q(ctrl_q),
    .load_wr(load_wr), .clr_wr(clr_wr));

  wdog_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run_en(ctrl_q.run_en),
    .load_wr(load_wr), .load_wdata(pwdata), .clr_wr(clr_wr),
    .load_q(load_q), .count(count), .expire(expire));

  wdog_status u_stat (
    .clk(clk), .rst_n(rst_sync_n), .expire(expire), .clr_wr(clr_wr),
    .int_en(ctrl_q.run_en), .rst_en(ctrl_q.rst_en), .pend(pend),
    .irq(irq), .wdt_rst(wdt_rst));
endmodule

// File: tb/wdog_twostage_test.sv
`timescale 1ns/1ps
module wdog_twostage_test;
  localparam logic [31:0] KEY = 32'h1ACCE551;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic irq, wdt_rst;
  int tests = 0, fails = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  wdog_twostage uut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq(irq), .wdt_rst(wdt_rst));

  function automatic logic [31:0] exp_ctrl(input logic [31:0] w);
    return w & 32'h3;
  endfunction
  function automatic logic [31:0] exp_lock(input logic [31:0] w);
    return (w == KEY) ? 32'd0 : 32'd1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    #1 d = prdata;
    psel = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    bus_rd(12'hC00, rd); check("R1 lock", rd, 32'd1);
    bus_rd(12'h008, rd); check("R1 ctrl", rd, 32'd0);
    bus_rd(12'h000, rd); check("R1 load", rd, 32'hFFFFFFFF);
    bus_rd(12'h004, rd); check("R1 value", rd, 32'hFFFFFFFF);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rst", {31'd0, wdt_rst}, 32'd0);

    bus_wr(12'h000, 32'd5);
    bus_rd(12'h000, rd); check("R3 load shut", rd, 32'hFFFFFFFF);
    bus_wr(12'h008, 32'd3);
    bus_rd(12'h008, rd); check("R3 ctrl shut", rd, 32'd0);

    bus_wr(12'hC00, KEY);
    bus_rd(12'hC00, rd); check("R2 open", rd, exp_lock(KEY));
    bus_wr(12'h008, 32'hFFFFFFFC);
    bus_rd(12'h008, rd); check("R11 ctrl pad", rd, exp_ctrl(32'hFFFFFFFC));
    bus_rd(12'h00C, rd); check("R11 clear reads 0", rd, 32'd0);
    bus_rd(12'h010, rd); check("R11 unmapped", rd, 32'd0);

    bus_wr(12'h000, 32'd100);
    bus_rd(12'h004, rd); check("R4 value loaded", rd, 32'd100);
    repeat (5) @(negedge clk);
    bus_rd(12'h004, rd); check("R5 hold", rd, 32'd100);
    bus_wr(12'h008, 32'd1);
    repeat (7) @(negedge clk);
    bus_rd(12'h004, rd); check("R5 decrement", rd, 32'd93);

    bus_wr(12'h000, 32'd3);
    repeat (4) @(negedge clk);
    check("R7 irq on", {31'd0, irq}, 32'd1);
    bus_rd(12'h014, rd); check("R7 status", rd, 32'd1);
    bus_wr(12'h008, 32'd0);
    check("R7 irq gated", {31'd0, irq}, 32'd0);
    bus_rd(12'h014, rd); check("R7 status kept", rd, 32'd1);
    bus_wr(12'h00C, 32'd0);
    bus_rd(12'h014, rd); check("R8 cleared", rd, 32'd0);
    bus_rd(12'h004, rd); check("R8 reloaded", rd, 32'd3);

    bus_wr(12'hC00, 32'h12345678);
    bus_rd(12'hC00, rd); check("R2 shut again", rd, exp_lock(32'h12345678));
    bus_wr(12'h000, 32'd9);
    bus_rd(12'h000, rd); check("R3 load kept", rd, 32'd3);

    for (int i = 0; i < 10; i++) begin
      int unsigned len;
      logic ren;
      len = $urandom % 24;
      ren = 1'($urandom % 2);
      if (i == 0) len = 0;
      do_reset();
      bus_wr(12'hC00, KEY);
      bus_wr(12'h008, {30'd0, ren, 1'b1});
      bus_wr(12'h000, len);
      bus_rd(12'h004, rd); check("R4 random load", rd, len);
      repeat (len) @(negedge clk);
      check("R6 no early irq", {31'd0, irq}, 32'd0);
      @(negedge clk);
      check("R6 first expiry", {31'd0, irq}, 32'd1);
      repeat (len) @(negedge clk);
      check("R9 no early rst", {31'd0, wdt_rst}, 32'd0);
      @(negedge clk);
      check(ren ? "R9 second expiry" : "R10 rst disabled", {31'd0, wdt_rst}, {31'd0, ren});
      repeat (3) @(negedge clk);
      check("R9 sticky", {31'd0, wdt_rst}, {31'd0, ren});
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule